// File: doc/BRIEF.md
# Pulse Count Threshold Event Unit

This unit sits next to a 16-bit signed pulse counter. It compares the running count with five reference points: zero, an upper limit, a lower limit and two free thresholds. Each comparison has its own enable. A comparator fires only in the cycle in which the count moves onto its reference value. It does not fire again while the count stays there.

When any enabled comparator fires, the unit stores a snapshot. The snapshot has one flag for each comparator that matched, plus a 2-bit code that tells how the count stands against zero. The same event sets an interrupt bit that has raw, enable, masked and write-one-to-clear behaviour. A hit on either limit also sends a one-cycle request back to the counter so that it wraps to zero. All configuration arrives as plain inputs. The bus registers that hold the configuration, and their reset values, live outside this block.

Top module: `thrEvtUnit`

## Requirements
- R1: After reset the flags, the zero code, the raw bit, the masked interrupt and the wrap request are all 0.
- R2: An enabled comparator fires when the count changes to a value equal to its reference. The next clock edge then sets the matching flag and the raw bit. Flag and enable positions are: bit 0 zero, bit 1 upper limit, bit 2 lower limit, bit 3 threshold 0, bit 4 threshold 1.
- R3: A count that holds its value fires nothing. This includes a comparator that is enabled while the count already equals its reference.
- R4: A disabled comparator never fires. Its flag reads 0 even when the count equals its reference during another comparator's event.
- R5: When several enabled comparators match in the same cycle, every one of their flags is set together.
- R6: Each event latches a zero code. The code is 0 when the count fell from positive to zero, 1 when it rose from negative to zero, 2 when the count is negative and 3 when it is positive.
- R7: An event that includes the upper or lower limit raises the wrap request for exactly one cycle. Events on the other comparators alone do not raise it.
- R8: The masked interrupt equals the raw bit AND the interrupt enable.
- R9: A cycle with the clear input at 1 drops the raw bit. If an event happens in the same cycle, the event wins and the raw bit stays 1.
- R10: The flags and the zero code hold their value, even across a clear, until the next event overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| count | input | 16 | Current signed count from the counter |
| cmpEnable | input | 5 | Per-comparator enable (bit order as in R2) |
| highLimit | input | 16 | Upper limit reference |
| lowLimit | input | 16 | Lower limit reference |
| thresh0 | input | 16 | Threshold 0 reference |
| thresh1 | input | 16 | Threshold 1 reference |
| intEnable | input | 1 | Interrupt enable |
| intClear | input | 1 | Write-one-to-clear strobe for the raw bit |
| eventFlags | output | 5 | Latched per-comparator match flags |
| zeroStatus | output | 2 | Latched zero relation code |
| wrapReq | output | 1 | One-cycle request to wrap the counter to zero |
| intRaw | output | 1 | Raw interrupt bit |
| intPending | output | 1 | Masked interrupt output |

## Verification
The bench builds the unit with its default 16-bit count width. That width makes negative references such as -50 expressible, so the code values 1 and 2 and the lower-limit wrap are all reachable. With one short walk, the count is driven onto each reference in turn. The walk also sets threshold 0 and threshold 1 equal at 20, which produces a double match, and it lines up an event with a clear in the same cycle.

// File: rtl/thrEvtPkg.sv
package thrEvtPkg;
  localparam int NUM_CMP = 5;
  localparam int CMP_ZERO = 0;
  localparam int CMP_HIGH = 1;
  localparam int CMP_LOW  = 2;
  localparam int CMP_T0   = 3;
  localparam int CMP_T1   = 4;

  typedef enum logic [1:0] {
    ZC_FELL = 2'd0,
    ZC_ROSE = 2'd1,
    ZC_NEG  = 2'd2,
    ZC_POS  = 2'd3
  } zeroCode_e;

  typedef struct packed {
    logic capture;
    logic wrapHit;
  } ctlStrobe_t;
endpackage

// File: rtl/thrEvtDatapath.sv
module thrEvtDatapath
  import thrEvtPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [CNT_W-1:0]                count,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmpVal,
  input  logic [NUM_CMP-1:0]              cmpEn,
  input  ctlStrobe_t                      strobe,
  output logic [NUM_CMP-1:0]              hitVec,
  output logic [NUM_CMP-1:0]              flags,
  output logic [1:0]                      zeroCode
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] prevCount;
  logic             changed;
  zeroCode_e        codeNext;

  assign changed = (count != prevCount);

  // One equality comparator per reference value.
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign hitVec[i] = cmpEn[i] & changed & (count == cmpVal[i]);
  end

  always_comb begin
    if (count == '0) begin
      codeNext = prevCount[MSB] ? ZC_ROSE : ZC_FELL;
    end else if (count[MSB]) begin
      codeNext = ZC_NEG;
    end else begin
      codeNext = ZC_POS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCount <= '0;
      flags     <= '0;
      zeroCode  <= 2'd0;
    end else begin
      prevCount <= count;
      if (strobe.capture) begin
        flags    <= hitVec;
        zeroCode <= codeNext;
      end
    end
  end
endmodule

// File: rtl/thrEvtControl.sv
module thrEvtControl
  import thrEvtPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CMP-1:0] hitVec,
  input  logic               intEnable,
  input  logic               intClear,
  output ctlStrobe_t         strobe,
  output logic               wrapReq,
  output logic               intRaw,
  output logic               intPending
);
  always_comb begin
    strobe.capture = |hitVec;
    strobe.wrapHit = hitVec[CMP_HIGH] | hitVec[CMP_LOW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intRaw  <= 1'b0;
      wrapReq <= 1'b0;
    end else begin
      // A new event has priority over a clear in the same cycle.
      intRaw  <= strobe.capture | (intRaw & ~intClear);
      wrapReq <= strobe.wrapHit;
    end
  end

  assign intPending = intRaw & intEnable;
endmodule

// File: rtl/thrEvtUnit.sv
module thrEvtUnit
  import thrEvtPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   count,
  input  logic [NUM_CMP-1:0] cmpEnable,
  input  logic [CNT_W-1:0]   highLimit,
  input  logic [CNT_W-1:0]   lowLimit,
  input  logic [CNT_W-1:0]   thresh0,
  input  logic [CNT_W-1:0]   thresh1,
  input  logic               intEnable,
  input  logic               intClear,
  output logic [NUM_CMP-1:0] eventFlags,
  output logic [1:0]         zeroStatus,
  output logic               wrapReq,
  output logic               intRaw,
  output logic               intPending
);
  logic [NUM_CMP-1:0][CNT_W-1:0] cmpVal;
  logic [NUM_CMP-1:0]            hitVec;
  ctlStrobe_t                    strobe;

  always_comb begin
    cmpVal[CMP_ZERO] = '0;
    cmpVal[CMP_HIGH] = highLimit;
    cmpVal[CMP_LOW]  = lowLimit;
    cmpVal[CMP_T0]   = thresh0;
    cmpVal[CMP_T1]   = thresh1;
  end

  thrEvtDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .count    (count),
    .cmpVal   (cmpVal),
    .cmpEn    (cmpEnable),
    .strobe   (strobe),
    .hitVec   (hitVec),
    .flags    (eventFlags),
    .zeroCode (zeroStatus)
  );

  thrEvtControl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .hitVec     (hitVec),
    .intEnable  (intEnable),
    .intClear   (intClear),
    .strobe     (strobe),
    .wrapReq    (wrapReq),
    .intRaw     (intRaw),
    .intPending (intPending)
  );
endmodule

// File: rtl/thrEvtChecker.sv
module thrEvtChecker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] count,
  input logic [4:0]       eventFlags,
  input logic             wrapReq,
  input logic             intRaw,
  input logic             intPending,
  input logic             intClear
);
  // R7: the wrap request lasts a single cycle.
  p_wrap_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrapReq |=> !wrapReq);

  // R7: a wrap request always comes with a limit flag.
  p_wrap_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrapReq |-> (eventFlags[1] | eventFlags[2]));

  // R8: the masked output never shows without the raw bit.
  p_mask_raw_r8: assert property (@(posedge clk) disable iff (!rstN)
    intPending |-> intRaw);

  // R3: a count that holds its value sets nothing.
  p_no_refire_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(count) && !intRaw) |=> !intRaw);

  // R9: a clear without any change of count drops the raw bit.
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(count) && intClear) |=> !intRaw);
endmodule

bind thrEvtUnit thrEvtChecker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .count      (count),
  .eventFlags (eventFlags),
  .wrapReq    (wrapReq),
  .intRaw     (intRaw),
  .intPending (intPending),
  .intClear   (intClear)
);

// File: tb/tb_thrEvtUnit.sv
module tb_thrEvtUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] count = '0;
  logic [4:0]  cmpEnable = 5'b00111;
  logic [15:0] highLimit = 16'd100;
  logic [15:0] lowLimit = 16'hFFCE;   // -50
  logic [15:0] thresh0 = 16'd20;
  logic [15:0] thresh1 = 16'hFFF6;    // -10
  logic        intEnable = 1'b0;
  logic        intClear = 1'b0;
  logic [4:0]  eventFlags;
  logic [1:0]  zeroStatus;
  logic        wrapReq, intRaw, intPending;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    string      tag;
    logic [4:0] flags;
    logic [1:0] code;
    logic       raw;
    logic       wrap;
    logic       irq;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  thrEvtUnit dut (
    .clk(clk), .rstN(rstN), .count(count), .cmpEnable(cmpEnable),
    .highLimit(highLimit), .lowLimit(lowLimit), .thresh0(thresh0),
    .thresh1(thresh1), .intEnable(intEnable), .intClear(intClear),
    .eventFlags(eventFlags), .zeroStatus(zeroStatus), .wrapReq(wrapReq),
    .intRaw(intRaw), .intPending(intPending)
  );

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares design outputs just after the edge that follows each driven cycle.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      cmp(e.tag, "flags", {3'b0, eventFlags}, {3'b0, e.flags});
      cmp(e.tag, "zero", {6'b0, zeroStatus}, {6'b0, e.code});
      cmp(e.tag, "raw", {7'b0, intRaw}, {7'b0, e.raw});
      cmp(e.tag, "wrap", {7'b0, wrapReq}, {7'b0, e.wrap});
      cmp(e.tag, "irq", {7'b0, intPending}, {7'b0, e.irq});
    end
  end

  // Driver: one cycle of stimulus plus its expected result.
  task automatic step(input logic [15:0] c, input logic clr, input string tag,
                      input logic [4:0] f, input logic [1:0] code,
                      input logic raw, input logic wrap);
    expItem_t e;
    @(negedge clk);
    count = c;
    intClear = clr;
    e.tag = tag; e.flags = f; e.code = code; e.raw = raw; e.wrap = wrap;
    e.irq = raw & intEnable;
    expQ.push_back(e);
    @(posedge clk);
    #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step(16'd0, 0, "R1", 5'b00000, 2'd0, 0, 0);
    step(16'd5, 0, "R2", 5'b00000, 2'd0, 0, 0);
    step(16'd0, 0, "R2_R6", 5'b00001, 2'd0, 1, 0);
    step(16'd0, 0, "R3", 5'b00001, 2'd0, 1, 0);
    step(16'd0, 1, "R9_R10", 5'b00001, 2'd0, 0, 0);
    step(16'hFFFD, 0, "R10", 5'b00001, 2'd0, 0, 0);
    step(16'd0, 0, "R6", 5'b00001, 2'd1, 1, 0);
    step(16'd20, 1, "R4", 5'b00001, 2'd1, 0, 0);
    cmpEnable = 5'b01111;
    step(16'd20, 0, "R3", 5'b00001, 2'd1, 0, 0);
    step(16'd21, 0, "R10", 5'b00001, 2'd1, 0, 0);
    step(16'd20, 0, "R2_R6", 5'b01000, 2'd3, 1, 0);
    step(16'd100, 1, "R9_R7", 5'b00010, 2'd3, 1, 1);
    step(16'd0, 0, "R7", 5'b00001, 2'd0, 1, 0);
    intEnable = 1'b1;
    step(16'd0, 0, "R8", 5'b00001, 2'd0, 1, 0);
    step(16'd0, 1, "R8", 5'b00001, 2'd0, 0, 0);
    step(16'hFFCE, 0, "R7_R6", 5'b00100, 2'd2, 1, 1);
    step(16'd5, 0, "R7", 5'b00100, 2'd2, 1, 0);
    thresh1 = 16'd20;
    cmpEnable = 5'b11111;
    step(16'd20, 0, "R5", 5'b11000, 2'd3, 1, 0);
    step(16'd21, 0, "R10", 5'b11000, 2'd3, 1, 0);
    cmpEnable = 5'b10111;
    step(16'd20, 0, "R4", 5'b10000, 2'd3, 1, 0);
    @(negedge clk);
    intClear = 1'b0;
    repeat (3) @(posedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule